// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block sits on the controller side of an SDRAM interface. It takes the device into its low-power self-refresh state and brings it back out when asked. The host controller raises `enter_req` once all banks are precharged. The sequencer then issues the self-refresh command with the clock-enable pin held low, and keeps that pin low for as long as the device should sleep. While the device sleeps it also drops the clock-gate enable, so the memory clock can be stopped.

When `exit_req` arrives, the sequencer runs the wake-up in three steps. First it turns the clock back on and lets it settle for a set number of cycles. Then it raises the clock-enable pin and holds it through the exit window. Last, it waits out the row-cycle recovery plus one clock. Through all three steps only idle commands appear on the command pins. Normal traffic is blocked until `ready` returns high.

All pin outputs are registered. Every wait is a parameter counted in clock cycles. An exit request that arrives in the same cycle as entry, or during the entry cycle, is held and acted on as soon as self-refresh is reached.

Top module: `sr_seq_top`

## Requirements
- R1: An `enter_req` accepted while `ready` is high causes, in the next cycle, exactly one cycle with cs_n=0, ras_n=0, cas_n=0, we_n=1 and cke=0. `ready` is low in that cycle.
- R2: After the entry cycle, cke stays 0, clk_en stays 0 and `ready` stays 0 for as long as no exit request has been taken, however long that is.
- R3: During self-refresh the command pins carry DESEL (cs_n=1, ras_n=1, cas_n=1, we_n=1) when IDLE_DESEL=1, and NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) when IDLE_DESEL=0.
- R4: The cycle after an `exit_req` is sampled in self-refresh, clk_en goes to 1 while cke stays 0. This state lasts exactly T_CLK_STABLE cycles, with NOP on the pins.
- R5: After the clock-settle phase, cke is 1 and `ready` is 0 for exactly T_SRX + T_RC + 1 cycles. The pins carry NOP in every one of those cycles.
- R6: At the end of recovery, `ready` goes to 1 and `busy` to 0, while cke=1, clk_en=1 and the pins carry NOP.
- R7: An `exit_req` sampled in the entry cycle, or together with the accepted `enter_req`, is held. Self-refresh then lasts exactly one cycle before the clock-settle phase begins.
- R8: `enter_req` is acted on only while `ready` is high. Outside that, `busy` is 1 and the request has no effect on cke, clk_en or the command pins.
- R9: `exit_req` sampled while `ready` is high has no effect: cke, clk_en and `ready` stay 1 and the pins keep NOP.
- R10: After reset, cke=1, clk_en=1, the pins carry NOP, `ready`=1 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_req | input | 1 | Request to enter self-refresh |
| exit_req | input | 1 | Request to leave self-refresh |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Device clock enable |
| clk_en | output | 1 | Enable for the external memory-clock gate |
| ready | output | 1 | Device accepts normal commands |
| busy | output | 1 | A sequence is in progress; enter requests are ignored |

## Verification
A state register stuck or skipped shows at the pins within one cycle, because every pin is registered from the next state. A missing entry cycle shows as no self-refresh command. A skipped settle phase shows as cke rising together with clk_en. A wrong counter load shifts the cycle on which cke rises or `ready` returns, and the phase-length measurements catch any error of a single cycle. A lost exit-pending flag leaves the device asleep, which the early-exit scenario sees one cycle later.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ENTER    = 3'd1,
    ST_IN_SR    = 3'd2,
    ST_CLK_UP   = 3'd3,
    ST_CKE_WAIT = 3'd4,
    ST_RECOVER  = 3'd5,
    ST_READY    = 3'd6
  } sr_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_SREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  function automatic logic st_accepts(sr_state_e s);
    return (s == ST_IDLE) || (s == ST_READY);
  endfunction

endpackage

// File: rtl/sr_seq_timer.sv
module sr_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
  import sr_seq_pkg::*;
#(
  parameter int T_CLK_STABLE = 4,
  parameter int T_SRX        = 2,
  parameter int T_RC         = 8,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter_req,
  input  logic             exit_req,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output sr_state_e        state_d,
  output sr_state_e        state_q
);
  localparam logic [CNT_W-1:0] LD_CLK = CNT_W'(T_CLK_STABLE - 1);
  localparam logic [CNT_W-1:0] LD_SRX = CNT_W'(T_SRX - 1);
  localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(T_RC);

  logic exit_pend_q;
  logic exit_pend_d;

  always_comb begin
    state_d     = state_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    exit_pend_d = exit_pend_q;
    unique case (state_q)
      ST_IDLE, ST_READY: begin
        exit_pend_d = 1'b0;
        if (enter_req) begin
          state_d     = ST_ENTER;
          exit_pend_d = exit_req;
        end
      end
      ST_ENTER: begin
        state_d = ST_IN_SR;
        if (exit_req) exit_pend_d = 1'b1;
      end
      ST_IN_SR: begin
        if (exit_req || exit_pend_q) begin
          state_d     = ST_CLK_UP;
          tmr_load    = 1'b1;
          tmr_val     = LD_CLK;
          exit_pend_d = 1'b0;
        end
      end
      ST_CLK_UP: begin
        if (tmr_expired) begin
          state_d  = ST_CKE_WAIT;
          tmr_load = 1'b1;
          tmr_val  = LD_SRX;
        end
      end
      ST_CKE_WAIT: begin
        if (tmr_expired) begin
          state_d  = ST_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = LD_RC;
        end
      end
      ST_RECOVER: begin
        if (tmr_expired) state_d = ST_READY;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      exit_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      exit_pend_q <= exit_pend_d;
    end
  end
endmodule

// File: rtl/sr_seq_pins.sv
module sr_seq_pins
  import sr_seq_pkg::*;
#(
  parameter bit IDLE_DESEL = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  sr_state_e state_d,
  output sd_cmd_t   cmd_q,
  output logic      cke_q,
  output logic      clk_en_q,
  output logic      ready_q,
  output logic      busy_q
);
  sd_cmd_t sleep_cmd;

  generate
    if (IDLE_DESEL) begin : g_desel
      assign sleep_cmd = CMD_DESEL;
    end else begin : g_nop
      assign sleep_cmd = CMD_NOP;
    end
  endgenerate

  sd_cmd_t cmd_d;
  logic    cke_d;
  logic    clk_en_d;

  always_comb begin
    cmd_d    = CMD_NOP;
    cke_d    = 1'b1;
    clk_en_d = 1'b1;
    unique case (state_d)
      ST_ENTER: begin
        cmd_d = CMD_SREF;
        cke_d = 1'b0;
      end
      ST_IN_SR: begin
        cmd_d    = sleep_cmd;
        cke_d    = 1'b0;
        clk_en_d = 1'b0;
      end
      ST_CLK_UP: cke_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= CMD_NOP;
      cke_q    <= 1'b1;
      clk_en_q <= 1'b1;
      ready_q  <= 1'b1;
      busy_q   <= 1'b0;
    end else begin
      cmd_q    <= cmd_d;
      cke_q    <= cke_d;
      clk_en_q <= clk_en_d;
      ready_q  <= st_accepts(state_d);
      busy_q   <= !st_accepts(state_d);
    end
  end
endmodule

// File: rtl/sr_seq_top.sv
module sr_seq_top
  import sr_seq_pkg::*;
#(
  parameter int T_CLK_STABLE = 4,
  parameter int T_SRX        = 2,
  parameter int T_RC         = 8,
  parameter bit IDLE_DESEL   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic enter_req,
  input  logic exit_req,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic cke,
  output logic clk_en,
  output logic ready,
  output logic busy
);
  localparam int MAX_A = (T_CLK_STABLE > T_SRX) ? T_CLK_STABLE : T_SRX;
  localparam int MAX_T = (MAX_A > T_RC + 1) ? MAX_A : T_RC + 1;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  sr_state_e        state_d;
  sr_state_e        state_q;
  sd_cmd_t          cmd;

  sr_seq_fsm #(
    .T_CLK_STABLE(T_CLK_STABLE),
    .T_SRX       (T_SRX),
    .T_RC        (T_RC),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .enter_req  (enter_req),
    .exit_req   (exit_req),
    .tmr_expired(tmr_expired),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .state_d    (state_d),
    .state_q    (state_q)
  );

  sr_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  sr_seq_pins #(.IDLE_DESEL(IDLE_DESEL)) u_pins (
    .clk     (clk),
    .rst     (rst),
    .state_d (state_d),
    .cmd_q   (cmd),
    .cke_q   (cke),
    .clk_en_q(clk_en),
    .ready_q (ready),
    .busy_q  (busy)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
endmodule

// File: rtl/sr_seq_chk.sv
module sr_seq_chk #(
  parameter int T_SRX = 2,
  parameter int T_RC  = 8
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic cke,
  input logic clk_en,
  input logic ready
);
  localparam int HI_MIN = T_SRX + T_RC + 1;

  logic [15:0] hi_cnt_q;
  logic        is_sref;
  logic        is_idle_cmd;

  assign is_sref     = !cs_n && !ras_n && !cas_n && we_n;
  assign is_idle_cmd = cs_n || (ras_n && cas_n && we_n);

  always_ff @(posedge clk) begin
    if (rst) hi_cnt_q <= '0;
    else if (cke && !ready) hi_cnt_q <= (hi_cnt_q == 16'hFFFF) ? hi_cnt_q : hi_cnt_q + 1'b1;
    else hi_cnt_q <= '0;
  end

  AST_SREF_WITH_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
    is_sref |-> !cke); // R1
  AST_SREF_ONLY_FROM_READY: assert property (@(posedge clk) disable iff (rst)
    is_sref |-> $past(ready)); // R8
  AST_GATE_OFF_KEEPS_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
    !clk_en |-> !cke); // R2
  AST_CKE_RISE_AFTER_CLOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> ($past(clk_en) && is_idle_cmd)); // R4
  AST_RECOVERY_IDLE_CMD: assert property (@(posedge clk) disable iff (rst)
    (cke && !ready) |-> is_idle_cmd); // R5
  AST_READY_AFTER_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (hi_cnt_q >= 16'(HI_MIN))); // R6
endmodule

bind sr_seq_top sr_seq_chk #(.T_SRX(T_SRX), .T_RC(T_RC)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .cs_n  (cs_n),
  .ras_n (ras_n),
  .cas_n (cas_n),
  .we_n  (we_n),
  .cke   (cke),
  .clk_en(clk_en),
  .ready (ready)
);

// File: tb/tb_sr_seq_top.sv
`timescale 1ns/1ps
module tb_sr_seq_top;
  localparam int TCS  = 3;
  localparam int TSRX = 4;
  localparam int TRC  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enter_req = 1'b0;
  logic exit_req = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, clk_en, ready, busy;

  int n_checks = 0;
  int n_errs   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  sr_seq_top #(.T_CLK_STABLE(TCS), .T_SRX(TSRX), .T_RC(TRC), .IDLE_DESEL(1'b1)) dut (
    .clk(clk), .rst(rst), .enter_req(enter_req), .exit_req(exit_req),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .clk_en(clk_en), .ready(ready), .busy(busy)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [3:0] cmd();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  // Pin codes: NOP=0111, DESEL=1111, SREF=0001 (cs,ras,cas,we)
  task automatic count_phase(input logic c_cke, input logic c_en, input string req,
                             output int n);
    n = 0;
    while (cke === c_cke && clk_en === c_en && ready === 1'b0 && n < 200) begin
      chk(req, {28'd0, cmd()}, 32'h7);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_enter();
    enter_req = 1'b1;
    @(negedge clk);
    enter_req = 1'b0;
    chk("R1 sref cmd", {28'd0, cmd()}, 32'h1);
    chk("R1 cke low", {31'd0, cke}, 32'd0);
    chk("R1 ready low", {31'd0, ready}, 32'd0);
    @(negedge clk);
    chk("R1 single entry cycle", {28'd0, cmd()}, 32'hF);
  endtask

  task automatic do_exit_and_measure();
    int n;
    exit_req = 1'b1;
    @(negedge clk);
    exit_req = 1'b0;
    count_phase(1'b0, 1'b1, "R4 settle NOP", n);
    chk("R4 settle length", n, TCS);
    count_phase(1'b1, 1'b1, "R5 recovery NOP", n);
    chk("R5 cke-high window", n, TSRX + TRC + 1);
    chk("R6 ready", {31'd0, ready}, 32'd1);
    chk("R6 busy", {31'd0, busy}, 32'd0);
    chk("R6 cke/clk_en", {30'd0, cke, clk_en}, 32'd3);
    chk("R6 NOP", {28'd0, cmd()}, 32'h7);
  endtask

  task automatic t_reset();
    chk("R10 cke", {31'd0, cke}, 32'd1);
    chk("R10 clk_en", {31'd0, clk_en}, 32'd1);
    chk("R10 NOP", {28'd0, cmd()}, 32'h7);
    chk("R10 ready", {31'd0, ready}, 32'd1);
    chk("R10 busy", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_full_cycle(int hold);
    do_enter();
    for (int i = 0; i < hold; i++) begin
      chk("R2 cke low", {31'd0, cke}, 32'd0);
      chk("R2 clock gated", {31'd0, clk_en}, 32'd0);
      chk("R2 ready low", {31'd0, ready}, 32'd0);
      chk("R3 DESEL in SR", {28'd0, cmd()}, 32'hF);
      @(negedge clk);
    end
    do_exit_and_measure();
  endtask

  task automatic t_early_exit();
    int n;
    enter_req = 1'b1;
    @(negedge clk);
    enter_req = 1'b0;
    exit_req  = 1'b1;
    chk("R7 sref cmd", {28'd0, cmd()}, 32'h1);
    @(negedge clk);
    exit_req = 1'b0;
    chk("R7 one SR cycle", {30'd0, cke, clk_en}, 32'd0);
    @(negedge clk);
    count_phase(1'b0, 1'b1, "R7 settle NOP", n);
    chk("R7 settle after held exit", n, TCS);
    count_phase(1'b1, 1'b1, "R7 recovery NOP", n);
    chk("R7 window", n, TSRX + TRC + 1);
  endtask

  task automatic t_same_cycle_exit();
    int n;
    enter_req = 1'b1;
    exit_req  = 1'b1;
    @(negedge clk);
    enter_req = 1'b0;
    exit_req  = 1'b0;
    chk("R7 sref with both reqs", {28'd0, cmd()}, 32'h1);
    @(negedge clk);
    chk("R7 SR one cycle (same-cycle)", {30'd0, cke, clk_en}, 32'd0);
    @(negedge clk);
    count_phase(1'b0, 1'b1, "R7 settle NOP", n);
    chk("R7 settle length (same-cycle)", n, TCS);
    count_phase(1'b1, 1'b1, "R7 recovery NOP", n);
    chk("R7 ready after held exit", {31'd0, ready}, 32'd1);
  endtask

  task automatic t_ignored_enter();
    do_enter();
    enter_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 busy in SR", {31'd0, busy}, 32'd1);
      chk("R8 enter ignored cke", {31'd0, cke}, 32'd0);
      chk("R8 enter ignored cmd", {28'd0, cmd()}, 32'hF);
    end
    enter_req = 1'b0;
    exit_req  = 1'b1;
    @(negedge clk);
    exit_req  = 1'b0;
    enter_req = 1'b1;
    for (int i = 0; i < TCS + TSRX + TRC + 1; i++) begin
      chk("R8 enter ignored during exit", {28'd0, cmd()}, 32'h7);
      chk("R8 busy during exit", {31'd0, busy}, 32'd1);
      @(negedge clk);
    end
    enter_req = 1'b0;
    chk("R8 ready after ignored enters", {31'd0, ready}, 32'd1);
    @(negedge clk);
    chk("R8 no late entry", {28'd0, cmd()}, 32'h7);
  endtask

  task automatic t_ignored_exit();
    exit_req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 cke stays", {31'd0, cke}, 32'd1);
      chk("R9 clk_en stays", {31'd0, clk_en}, 32'd1);
      chk("R9 ready stays", {31'd0, ready}, 32'd1);
      chk("R9 NOP", {28'd0, cmd()}, 32'h7);
    end
    exit_req = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=%0d expected<200000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ignored_exit();
    t_full_cycle(6);
    t_full_cycle(40);
    t_early_exit();
    t_same_cycle_exit();
    t_ignored_enter();
    t_full_cycle(1);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule